// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

The block merges a small set of synchronous interrupt request lines into one active-low interrupt line for a host processor. Every source owns a sticky status flag, which is set on any rising clock edge where its request is high and kept until software clears it, and an enable flag set by software. The output goes low while at least one source has both its status and its enable flag at 1.

Software reaches the block through a single-cycle synchronous register port with two addresses: a status register that reads the flags and clears a flag when a 0 is written to its bit, and an enable register that reads and writes the mask. A request that is still high re-arms its flag on the next edge, so a source that has not been serviced cannot be lost by a clear.

Top module: `irq_merge`

## Requirements
- R1: There are N_SRC sources (default 3). Address 0 reads the status flags and address 1 reads the enable flags, in bit k for source k. Bits at and above N_SRC read as 0 across the DW-bit data word.
- R2: irq_no is 0 when some source has both status and enable at 1, and 1 otherwise. It follows the flags combinationally and changes in the same cycle as they do.
- R3: An enable flag holds the value last written to address 1 and is never changed by hardware or by request activity.
- R4: At every rising edge where req_i[k] is 1, status bit k becomes 1. While req_i[k] is 0 and no clear is written, the bit keeps its value.
- R5: A write to address 0 with a 0 in bit k clears status bit k when req_i[k] is 0 in that cycle.
- R6: A 1 written to a status bit leaves that bit unchanged.
- R7: When a clear of bit k and a high req_i[k] fall on the same edge, the bit ends at 1.
- R8: While rst_ni is 0, all status and enable flags are 0 and irq_no is 1.
- R9: A write to one address does not change the other register. With we_i at 0 nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Synchronous interrupt requests |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 1 | Register select: 0 status, 1 enable |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, zero-extended |
| irq_no | output | 1 | Combined interrupt, active low |

## Verification
The bench sweeps every enable mask against every preloaded status pattern. For each pair it then walks every status write mask against every simultaneous request pattern. Comparing the expected status (old flags ANDed with the written mask, ORed with the live requests) separates a correct clear from a lost or stray flag, and it separates the set-wins rule from clear-wins. The same combinations drive the output through all AND/NOR cases. The idle cycles after each request pulse show that flags are sticky. A mid-run reset and a long hold of the enables show that reset dominates and that hardware never changes the mask.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  typedef enum logic {
    SEL_STAT = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irqm_src_cell.sv
module irqm_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  output logic stat_o
);
  // set dominates clear so a pending request is never dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_o <= 1'b0;
    else if (req_i)   stat_o <= 1'b1;
    else if (clr_i)   stat_o <= 1'b0;
  end
endmodule

// File: rtl/irqm_en_reg.sv
module irqm_en_reg #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (we_i) en_o <= wdata_i;
  end
endmodule

// File: rtl/irqm_readmux.sv
module irqm_readmux #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned DW    = 8
) (
  input  irqm_pkg::reg_sel_e sel_i,
  input  logic [N_SRC-1:0]   stat_i,
  input  logic [N_SRC-1:0]   en_i,
  output logic [DW-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    rdata_o[N_SRC-1:0] = (sel_i == irqm_pkg::SEL_EN) ? en_i : stat_i;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_no
);
  import irqm_pkg::*;

  reg_sel_e         sel;
  logic             stat_we;
  logic             en_we;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] stat_w;
  logic [N_SRC-1:0] en_w;

  assign sel     = reg_sel_e'(addr_i);
  assign stat_we = we_i && (sel == SEL_STAT);
  assign en_we   = we_i && (sel == SEL_EN);
  assign clr_vec = {N_SRC{stat_we}} & ~wdata_i[N_SRC-1:0];

  generate
    if (DW > N_SRC) begin : g_unused_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DW-1:N_SRC];
    end
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
      irqm_src_cell u_cell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i[k]),
        .clr_i  (clr_vec[k]),
        .stat_o (stat_w[k])
      );
    end
  endgenerate

  irqm_en_reg #(.N_SRC(N_SRC)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we),
    .wdata_i (wdata_i[N_SRC-1:0]),
    .en_o    (en_w)
  );

  irqm_readmux #(.N_SRC(N_SRC), .DW(DW)) u_rd (
    .sel_i   (sel),
    .stat_i  (stat_w),
    .en_i    (en_w),
    .rdata_o (rdata_o)
  );

  // NOR of per-source ANDs
  assign irq_no = ~|(stat_w & en_w);
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int unsigned N_SRC = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic             we_i,
  input logic             addr_i,
  input logic [N_SRC-1:0] wd_i,
  input logic [N_SRC-1:0] stat_i,
  input logic [N_SRC-1:0] en_i,
  input logic             irq_no
);
  // R2: output low exactly when an enabled flag is pending
  a_r2_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_no == 1'b0) == ((stat_i & en_i) != '0));

  // R3 / R9: enable changes only through a write to address 1
  a_r3_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i) |=> $stable(en_i));

  a_r3_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i) |=> (en_i == $past(wd_i)));

  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    // R4, R7: request sets the flag, winning over a clear
    a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[k] |=> stat_i[k]);
    // R4, R6: held unless a 0 is written
    a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_i[k] && !(we_i && !addr_i && !wd_i[k])) |=> stat_i[k]);
    // R5: clear by writing 0
    a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !addr_i && !wd_i[k] && !req_i[k]) |=> !stat_i[k]);
    // R4: no flag rises without a request
    a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_i[k] && !req_i[k]) |=> !stat_i[k]);
  end
endmodule

bind irq_merge irq_merge_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wd_i   (wdata_i[N_SRC-1:0]),
  .stat_i (stat_w),
  .en_i   (en_w),
  .irq_no (irq_no)
);

// File: tb/irq_merge_bench.sv
`timescale 1ns/1ps
module irq_merge_bench;
  localparam int N  = 3;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic          we_i = 1'b0;
  logic          addr_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_no;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [N-1:0] m_stat = '0;
  logic [N-1:0] m_en   = '0;

  always #2.5 clk_i = ~clk_i;

  irq_merge #(.N_SRC(N), .DW(DW)) u_irq_merge (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_no
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model update at edge, settle after it
  task automatic step(logic [N-1:0] rq, logic w, logic a, logic [DW-1:0] d);
    @(negedge clk_i);
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    if (w && !a) m_stat = (m_stat & d[N-1:0]) | rq;
    else         m_stat = m_stat | rq;
    if (w && a)  m_en = d[N-1:0];
    #1;
    req_i = '0; we_i = 1'b0;
  endtask

  // read both registers and the output between edges
  task automatic check_all(string tag);
    addr_i = 1'b0; #0.2;
    chk({tag, " R1/R4/R5/R6/R7 status"}, rdata_o, DW'(m_stat));
    chk({tag, " R2 irq"}, DW'(irq_no), DW'((m_stat & m_en) == '0));
    addr_i = 1'b1; #0.2;
    chk({tag, " R1/R3/R9 enable"}, rdata_o, DW'(m_en));
  endtask

  initial begin
    // R8: reset state
    #7;
    chk("R8 reset irq", DW'(irq_no), DW'(1));
    addr_i = 1'b0; #0.2; chk("R8 reset status", rdata_o, '0);
    addr_i = 1'b1; #0.2; chk("R8 reset enable", rdata_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int e = 0; e < 8; e++)
      for (int s = 0; s < 8; s++)
        for (int m = 0; m < 8; m++)
          for (int r = 0; r < 8; r++) begin
            step('0, 1'b1, 1'b1, DW'(e) | 8'hF8);   // R9: status untouched
            step(N'(s), 1'b0, 1'b0, '0);             // R4: set by request
            step('0, 1'b1, 1'b1, DW'(e));            // same value again
            if (r == 0 && m == 0) check_all("preload");
            step('0, 1'b0, 1'b1, '0);                // R9: we_i low, no write
            step(N'(r), 1'b1, 1'b0, DW'(m) | 8'hF8); // R5/R6/R7
            check_all("sweep");
            step('0, 1'b1, 1'b0, '0);                // R5: full clear
            if (m == 7 && r == 7) check_all("clear");
          end

    // R3: enable held across request activity
    step('0, 1'b1, 1'b1, 8'h05);
    for (int i = 0; i < 20; i++) step(N'(i), 1'b0, 1'b0, '0);
    check_all("R3 hold");

    // R8: reset mid-run
    @(negedge clk_i); rst_ni = 1'b0; #0.5;
    m_stat = '0; m_en = '0;
    check_all("R8 midrun");
    @(negedge clk_i); rst_ni = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule